// File: doc/BRIEF.md
# Powered-Port Detect, Classify and Power Sequencer

This block carries one power-delivery port through its connection sequence. Its time base is a one-millisecond tick. After power-on reset it stays quiet for a fixed settling time. It then runs a resistance-detection phase. A failed or overlong detection is followed by a backoff pause. The pause is short when the port voltage sits close to the supply and long otherwise. A good detection leads to classification, which is either a single class event or two class events, each followed by a mark interval. After that the gate is enabled, automatically or on command. While the port is powered, a monitor watches for the load's maintain-power signature and removes power once the signature has been gone for a programmable dropout time.

The measurement front end sits outside the block. It reports the end of each detection and its verdict, each class result, whether the port is near the supply rail, and whether the maintain signature is present. The block answers with one enable per phase, a gate enable, and the latched results of the last detection and the last classification. Shutdown and port reset remove gate drive in the same cycle, without waiting for a clock edge. Both also send the sequencer back to idle.

Top module: `psq_port_seq`

## Requirements
- R1: After reset all enables are low and both status fields read 0. No phase enable rises until POR_MS (23) ticks have been counted. After that the sequence starts within three clock cycles.
- R2: With mode 00 (off), the sequencer leaves any phase other than the power-on wait and goes to idle on the next clock. It then stays there with the gate and every phase enable low.
- R3: A detect-done strobe with valid high moves the port from detection to classification and sets det_stat to 1. With valid low, det_stat becomes 2 and the port enters backoff. If no strobe arrives within DET_MAX_MS (500) ticks, det_stat becomes 3 and the port enters backoff.
- R4: Backoff lasts BOFF_NEAR_MS (100) ticks when near_supply was high on entry and BOFF_FAR_MS (400) ticks otherwise. Detection then restarts.
- R5: In one-event classification, a class strobe latches cls_code into cls_stat. In mode 11 (auto) the gate is enabled on the next clock.
- R6: With two_event high, each class strobe is followed by a mark phase of MARK_MS (8) ticks. The first mark leads to the second class event. The second mark leads to power-on, and cls_stat keeps the second result.
- R7: If no class strobe arrives within CLS_MAX_MS (13) ticks of a class phase starting, cls_stat becomes 7 and the port enters backoff.
- R8: In mode 10 (semi-auto), a classified port waits with the gate low. The gate is enabled on the clock after a power-on command.
- R9: In mode 01 (manual), no detection runs. A power-on command from idle enables the gate on the next clock.
- R10: A power-off command drops the gate on the next clock.
- R11: Shutdown or port reset drops the gate in the same cycle and returns the sequencer to idle on the next clock.
- R12: A powered port loses power after drop_sel's limit of consecutive ticks without the maintain signature. The limits are 00: 350, 01: 88, 10: 175 and 11: 700 ticks. Any cycle with the signature present restarts the count.
- R13: At most one of det_en, cls_en, mark_en and gate_en is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| mode | input | 2 | 00 off, 01 manual, 10 semi-auto, 11 auto |
| two_event | input | 1 | Selects two-event classification |
| drop_sel | input | 2 | Maintain-signature dropout limit select |
| det_done | input | 1 | Detection finished strobe |
| det_valid | input | 1 | Detection verdict, sampled with det_done |
| cls_strobe | input | 1 | Class result strobe |
| cls_code | input | 3 | Class result, sampled with cls_strobe |
| near_supply | input | 1 | Port voltage close to the supply rail |
| mps_ok | input | 1 | Maintain-power signature present |
| shutdown | input | 1 | Immediate gate kill and return to idle |
| port_rst | input | 1 | Port reset, same effect as shutdown |
| pwr_on_cmd | input | 1 | Power-on command (manual or semi-auto) |
| pwr_off_cmd | input | 1 | Power-off command |
| det_en | output | 1 | Detection phase enable |
| cls_en | output | 1 | Class event enable |
| mark_en | output | 1 | Mark interval enable |
| gate_en | output | 1 | Port power gate enable |
| det_stat | output | 2 | Last detection result: 0 none, 1 valid, 2 invalid, 3 timeout |
| cls_stat | output | 3 | Last class result, 7 on class timeout |

## Verification
The assertions assume that det_done, cls_strobe and the power commands are single-cycle pulses, and that the tick is a single-cycle pulse with idle cycles between ticks. They also assume that no strobe arrives in the same cycle as a tick or as a phase change. The stimulus drives every input on the falling edge. It issues each tick as one high cycle followed by three low cycles, and it fires strobes only in quiet cycles while the matching phase enable is high. Under these conditions the phase timer always restarts on a phase change, and every counted limit can be checked at a single tick boundary.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_MANUAL = 2'd1,
    MD_SEMI   = 2'd2,
    MD_AUTO   = 2'd3
  } psq_mode_e;

  typedef enum logic [3:0] {
    ST_POR   = 4'd0,
    ST_IDLE  = 4'd1,
    ST_DET   = 4'd2,
    ST_BOFF  = 4'd3,
    ST_CLS1  = 4'd4,
    ST_MARK1 = 4'd5,
    ST_CLS2  = 4'd6,
    ST_MARK2 = 4'd7,
    ST_READY = 4'd8,
    ST_PWR   = 4'd9
  } psq_state_e;

  localparam logic [1:0] DS_VALID   = 2'd1;
  localparam logic [1:0] DS_INVALID = 2'd2;
  localparam logic [1:0] DS_TIMEOUT = 2'd3;
  localparam logic [2:0] CS_TIMEOUT = 3'd7;

endpackage

// File: rtl/psq_phase_timer.sv
module psq_phase_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  localparam logic [TW-1:0] CMAX = '1;

  logic [TW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (tick && count != CMAX) count <= count + 1'b1;
  end

  assign expired = (count >= limit);

  AST_TMR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CMAX) |=> (count == CMAX)); // R4

endmodule

// File: rtl/psq_mps_monitor.sv
module psq_mps_monitor #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          powered,
  input  logic          mps_ok,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          drop_evt
);
  localparam logic [TW-1:0] CMAX = '1;

  logic [TW-1:0] absent_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               absent_cnt <= '0;
    else if (!powered || mps_ok)              absent_cnt <= '0;
    else if (tick && absent_cnt != CMAX)      absent_cnt <= absent_cnt + 1'b1;
  end

  assign drop_evt = powered && (absent_cnt >= limit);

  AST_MPS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mps_ok |=> (absent_cnt == '0)); // R12

endmodule

// File: rtl/psq_port_seq.sv
module psq_port_seq
  import psq_pkg::*;
#(
  parameter int TW           = 10,
  parameter int POR_MS       = 23,
  parameter int DET_MAX_MS   = 500,
  parameter int BOFF_FAR_MS  = 400,
  parameter int BOFF_NEAR_MS = 100,
  parameter int CLS_MAX_MS   = 13,
  parameter int MARK_MS      = 8,
  parameter int DROP_MS_0    = 350,
  parameter int DROP_MS_1    = 88,
  parameter int DROP_MS_2    = 175,
  parameter int DROP_MS_3    = 700
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic [1:0] mode,
  input  logic       two_event,
  input  logic [1:0] drop_sel,
  input  logic       det_done,
  input  logic       det_valid,
  input  logic       cls_strobe,
  input  logic [2:0] cls_code,
  input  logic       near_supply,
  input  logic       mps_ok,
  input  logic       shutdown,
  input  logic       port_rst,
  input  logic       pwr_on_cmd,
  input  logic       pwr_off_cmd,
  output logic       det_en,
  output logic       cls_en,
  output logic       mark_en,
  output logic       gate_en,
  output logic [1:0] det_stat,
  output logic [2:0] cls_stat
);

  localparam logic [TW-1:0] NO_LIMIT = '1;

  function automatic logic [TW-1:0] drop_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return TW'(DROP_MS_0);
      2'd1:    return TW'(DROP_MS_1);
      2'd2:    return TW'(DROP_MS_2);
      default: return TW'(DROP_MS_3);
    endcase
  endfunction

  function automatic logic [TW-1:0] phase_limit(input psq_state_e s, input logic near);
    case (s)
      ST_POR:             return TW'(POR_MS);
      ST_DET:             return TW'(DET_MAX_MS);
      ST_BOFF:            return near ? TW'(BOFF_NEAR_MS) : TW'(BOFF_FAR_MS);
      ST_CLS1, ST_CLS2:   return TW'(CLS_MAX_MS);
      ST_MARK1, ST_MARK2: return TW'(MARK_MS);
      default:            return NO_LIMIT;
    endcase
  endfunction

  psq_state_e st, st_nx;
  psq_mode_e  md;
  logic       boff_near;
  logic       tmr_exp, tmr_clr, drop_evt;

  assign md = psq_mode_e'(mode);

  // named events for the checks below
  logic force_idle, auto_seq, in_auto_phase;
  logic det_pass, det_fail, det_tmo, cls_hit, cls_tmo;

  assign force_idle    = shutdown || port_rst || (md == MD_OFF);
  assign auto_seq      = (md == MD_SEMI) || (md == MD_AUTO);
  assign in_auto_phase = (st inside {ST_DET, ST_BOFF, ST_CLS1, ST_MARK1,
                                     ST_CLS2, ST_MARK2, ST_READY});
  assign det_pass = (st == ST_DET) && det_done && det_valid;
  assign det_fail = (st == ST_DET) && det_done && !det_valid;
  assign det_tmo  = (st == ST_DET) && !det_done && tmr_exp;
  assign cls_hit  = ((st == ST_CLS1) || (st == ST_CLS2)) && cls_strobe;
  assign cls_tmo  = ((st == ST_CLS1) || (st == ST_CLS2)) && !cls_strobe && tmr_exp;

  always_comb begin
    st_nx = st;
    if (st == ST_POR) begin
      if (tmr_exp) st_nx = ST_IDLE;
    end else if (force_idle || (in_auto_phase && !auto_seq)) begin
      st_nx = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:  if (auto_seq) st_nx = ST_DET;
                  else if (md == MD_MANUAL && pwr_on_cmd) st_nx = ST_PWR;
        ST_DET:   if (det_pass) st_nx = ST_CLS1;
                  else if (det_fail || det_tmo) st_nx = ST_BOFF;
        ST_BOFF:  if (tmr_exp) st_nx = ST_IDLE;
        ST_CLS1:  if (cls_hit) st_nx = two_event ? ST_MARK1 :
                                       (md == MD_AUTO ? ST_PWR : ST_READY);
                  else if (cls_tmo) st_nx = ST_BOFF;
        ST_MARK1: if (tmr_exp) st_nx = ST_CLS2;
        ST_CLS2:  if (cls_hit) st_nx = ST_MARK2;
                  else if (cls_tmo) st_nx = ST_BOFF;
        ST_MARK2: if (tmr_exp) st_nx = (md == MD_AUTO) ? ST_PWR : ST_READY;
        ST_READY: if (pwr_on_cmd || md == MD_AUTO) st_nx = ST_PWR;
        ST_PWR:   if (pwr_off_cmd || drop_evt) st_nx = ST_IDLE;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  assign tmr_clr = (st_nx != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_POR;
      boff_near <= 1'b0;
      det_stat  <= '0;
      cls_stat  <= '0;
    end else begin
      st <= st_nx;
      if (st_nx == ST_BOFF && st != ST_BOFF) boff_near <= near_supply;
      if (!force_idle) begin
        if (det_pass)      det_stat <= DS_VALID;
        else if (det_fail) det_stat <= DS_INVALID;
        else if (det_tmo)  det_stat <= DS_TIMEOUT;
        if (cls_hit)       cls_stat <= cls_code;
        else if (cls_tmo)  cls_stat <= CS_TIMEOUT;
      end
    end
  end

  psq_phase_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .tick    (tick_1ms),
    .limit   (phase_limit(st, boff_near)),
    .expired (tmr_exp)
  );

  psq_mps_monitor #(.TW(TW)) u_mps (
    .clk      (clk),
    .rst_n    (rst_n),
    .powered  (st == ST_PWR),
    .mps_ok   (mps_ok),
    .tick     (tick_1ms),
    .limit    (drop_limit(drop_sel)),
    .drop_evt (drop_evt)
  );

  assign det_en  = (st == ST_DET);
  assign cls_en  = (st == ST_CLS1) || (st == ST_CLS2);
  assign mark_en = (st == ST_MARK1) || (st == ST_MARK2);
  assign gate_en = (st == ST_PWR) && !shutdown && !port_rst;

  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POR && !tmr_exp) |=> (st == ST_POR)); // R1
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_POR && md == MD_OFF) |=> (st == ST_IDLE)); // R2
  AST_DET_PASS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (det_pass && !force_idle) |=> (det_stat == DS_VALID && cls_en)); // R3
  AST_MARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !tmr_exp && !force_idle && auto_seq) |=> mark_en); // R6
  AST_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PWR && pwr_off_cmd) |=> !gate_en); // R10
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_POR && (shutdown || port_rst)) |=> (st == ST_IDLE)); // R11
  AST_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (st == ST_IDLE)); // R12
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({det_en, cls_en, mark_en, gate_en})); // R13

endmodule

// File: tb/sim_psq_port_seq.sv
module sim_psq_port_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       two_event = 1'b0;
  logic [1:0] drop_sel = 2'd1;
  logic       det_done = 1'b0, det_valid = 1'b0;
  logic       cls_strobe = 1'b0;
  logic [2:0] cls_code = 3'd0;
  logic       near_supply = 1'b0, mps_ok = 1'b1;
  logic       shutdown = 1'b0, port_rst = 1'b0;
  logic       pwr_on_cmd = 1'b0, pwr_off_cmd = 1'b0;
  logic       det_en, cls_en, mark_en, gate_en;
  logic [1:0] det_stat;
  logic [2:0] cls_stat;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  psq_port_seq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_det(input logic ok);
    @(negedge clk) begin det_done = 1'b1; det_valid = ok; end
    @(negedge clk) det_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_cls(input logic [2:0] code);
    @(negedge clk) begin cls_strobe = 1'b1; cls_code = code; end
    @(negedge clk) cls_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_on();
    @(negedge clk) pwr_on_cmd = 1'b1;
    @(negedge clk) pwr_on_cmd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_off();
    @(negedge clk) pwr_off_cmd = 1'b1;
    @(negedge clk) pwr_off_cmd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_det();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 600 && !det_en; i++) tick_n(1);
    chk("R4 detection restarts", det_en, 1);
  endtask

  task automatic power_up_auto(input logic [2:0] code);
    wait_det();
    pulse_det(1'b1);
    pulse_cls(code);
    chk("R5 gate after one-event class", gate_en, 1);
  endtask

  task automatic t_reset_por();
    chk("R1 reset gate", gate_en, 0);
    chk("R1 reset det_stat", det_stat, 0);
    chk("R1 reset cls_stat", cls_stat, 0);
    @(negedge clk) rst_n = 1'b1;
    tick_n(22);
    chk("R1 quiet before 23 ticks", det_en, 0);
    tick_n(1);
    chk("R1 detection after 23 ticks", det_en, 1);
  endtask

  task automatic t_det_fail(input logic near, input int len);
    near_supply = near;
    pulse_det(1'b0);
    near_supply = 1'b0;
    chk("R3 invalid det_stat", det_stat, 2);
    chk("R3 backoff after invalid", det_en, 0);
    tick_n(len - 1);
    chk("R4 still in backoff", det_en, 0);
    tick_n(1);
    repeat (2) @(negedge clk);
    chk("R4 backoff length", det_en, 1);
  endtask

  task automatic t_det_timeout();
    tick_n(499);
    chk("R3 detect before timeout", det_en, 1);
    tick_n(1);
    chk("R3 detect timeout leaves", det_en, 0);
    chk("R3 timeout det_stat", det_stat, 3);
    wait_det();
  endtask

  task automatic t_one_event();
    pulse_det(1'b1);
    chk("R3 valid det_stat", det_stat, 1);
    chk("R3 class after valid", cls_en, 1);
    pulse_cls(3'd3);
    chk("R5 cls_stat", cls_stat, 3);
    chk("R5 gate in auto", gate_en, 1);
    chk("R13 enables exclusive", det_en + cls_en + mark_en + gate_en, 1);
  endtask

  task automatic t_dropout(input logic [1:0] sel, input int lim);
    drop_sel = sel;
    @(negedge clk) mps_ok = 1'b0;
    tick_n(lim / 2);
    @(negedge clk) mps_ok = 1'b1;
    @(negedge clk) mps_ok = 1'b0;
    tick_n(lim - 1);
    chk("R12 signature restore restarts count", gate_en, 1);
    tick_n(1);
    chk("R12 dropout removes power", gate_en, 0);
    @(negedge clk) mps_ok = 1'b1;
  endtask

  task automatic t_class_timeout();
    wait_det();
    pulse_det(1'b1);
    tick_n(12);
    chk("R7 class before timeout", cls_en, 1);
    tick_n(1);
    chk("R7 class timeout leaves", cls_en, 0);
    chk("R7 class timeout code", cls_stat, 7);
  endtask

  task automatic t_two_event_semi();
    mode = 2'd2;
    two_event = 1'b1;
    wait_det();
    pulse_det(1'b1);
    pulse_cls(3'd4);
    chk("R6 first mark", mark_en, 1);
    tick_n(7);
    chk("R6 first mark length", mark_en, 1);
    tick_n(1);
    chk("R6 second class event", cls_en, 1);
    pulse_cls(3'd2);
    chk("R6 second mark", mark_en, 1);
    tick_n(8);
    chk("R6 mark ends", mark_en, 0);
    chk("R6 second class latched", cls_stat, 2);
    chk("R8 semi-auto waits", gate_en, 0);
    pulse_on();
    chk("R8 gate on command", gate_en, 1);
    two_event = 1'b0;
  endtask

  task automatic t_off_cmd();
    pulse_off();
    chk("R10 off command", gate_en, 0);
  endtask

  task automatic t_shutdown();
    mode = 2'd3;
    power_up_auto(3'd1);
    @(negedge clk) shutdown = 1'b1;
    #1 chk("R11 shutdown same cycle", gate_en, 0);
    @(negedge clk) shutdown = 1'b0;
    #1 chk("R11 idle after shutdown", gate_en, 0);
    power_up_auto(3'd1);
    @(negedge clk) port_rst = 1'b1;
    #1 chk("R11 port reset same cycle", gate_en, 0);
    @(negedge clk) port_rst = 1'b0;
  endtask

  task automatic t_manual_off();
    power_up_auto(3'd2);
    @(negedge clk) mode = 2'd1;
    pulse_off();
    tick_n(3);
    chk("R9 no detection in manual", det_en, 0);
    chk("R9 gate idle manual", gate_en, 0);
    pulse_on();
    chk("R9 manual power-on", gate_en, 1);
    @(negedge clk) mode = 2'd0;
    @(negedge clk);
    chk("R2 off mode drops gate", gate_en, 0);
    tick_n(3);
    chk("R2 off mode idle", det_en + cls_en + mark_en + gate_en, 0);
  endtask

  initial begin
    t_reset_por();
    t_det_fail(1'b1, 100);
    t_det_fail(1'b0, 400);
    t_det_timeout();
    t_one_event();
    t_dropout(2'd1, 88);
    power_up_auto(3'd0);
    t_dropout(2'd2, 175);
    t_class_timeout();
    t_two_event_semi();
    t_off_cmd();
    t_shutdown();
    t_manual_off();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule